// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is the controller side of a synchronous serial link that moves one word in each direction per frame. A single-period frame-sync pulse comes before each word. Software-side logic places words in an eight-entry transmit queue. Whenever that queue is not empty, the port starts a frame. It raises the sync pulse for one serial clock period and loads the word into its transmit shifter. It then shifts the word out most significant bit first while it shifts in the word returned by the remote device. At the end of the frame the received word goes into an eight-entry receive queue.

Data is launched on rising serial clock edges and sampled on falling edges. When more words are waiting, the next sync pulse follows the last data bit directly, with no idle period between frames. While no frame is running, the serial clock and the sync pulse stay low and the transmit line is released. The serial clock is derived from the system clock through a programmable even divider. All shifting runs on system-clock enable strobes. A receive-timeout flag reports that received words have been left unread while the link is idle. A sticky overrun flag records a word lost to a full receive queue.

Top module: `pfs_master`

## Requirements
- R1: The frame length is taken from `frame_bits`. Values 4 to 16 are used as given, values below 4 act as 4 and values above 16 act as 16. The bits of a frame are the low `frame_bits` bits of the queued word, sent from the highest of those bits down to bit 0.
- R2: During reset and whenever no frame is running, `sclk` and `fss` are 0 and `txd_oe` is 0.
- R3: A frame starts as soon as the transmit queue is non-empty. Its sync pulse on `fss` starts together with a rising edge of `sclk` and stays high for exactly one serial clock period.
- R4: The first data bit appears on `txd` at the rising `sclk` edge that ends the sync pulse. Every later bit changes only on a rising edge, and `rxd` is sampled on each falling edge.
- R5: The received bits are written to the receive queue right-aligned, first-received bit most significant and unused upper bits zero. The write happens at the first serial clock boundary after the last bit has been sampled.
- R6: One serial clock period lasts `clk_div` system clocks, with the high phase lasting half of it. An odd `clk_div` is rounded down and a value below 2 acts as 2. `sclk` toggles only while a frame runs.
- R7: `rx_timeout` goes high once the port has been idle with a non-empty receive queue for `timeout_periods` serial clock periods. A receive-queue read or a frame start clears it and restarts the count.
- R8: When a further word is already queued, the next sync pulse starts at the boundary that ends the last data bit. Sync pulses are then exactly (length + 1) serial periods apart.
- R9: A word that arrives while the receive queue is full is dropped, and `rx_overrun` is set and stays set until reset.
- R10: Each queue holds 8 words of 16 bits and reports full and empty. `rx_rd_data` shows the oldest stored word and `rx_rd_en` removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 8 | System clocks per serial clock period |
| frame_bits | input | 5 | Bits per frame, 4 to 16 |
| timeout_periods | input | 16 | Idle serial periods before the receive timeout |
| tx_wr_en | input | 1 | Push `tx_wr_data` into the transmit queue |
| tx_wr_data | input | 16 | Word to send |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rd_en | input | 1 | Remove the oldest received word |
| rx_rd_data | output | 16 | Oldest received word |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_timeout | output | 1 | Unread data left while idle |
| rx_overrun | output | 1 | Sticky: a received word was dropped |
| sclk | output | 1 | Serial clock |
| fss | output | 1 | Frame-sync pulse |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable for `txd` |
| rxd | input | 1 | Serial receive data |

## Verification
A bit index that is off by one, or a bad length clamp, corrupts the serial word that the bench captures. It shows up at the end of that same frame. It also shows up later, when the returned word is read from the receive queue. A divider or phase error changes the measured `sclk` high time and the measured sync-pulse width on the very first frame. A sequencer that inserts an idle gap between frames breaks the pulse-to-pulse spacing on the second word of a burst. Queue pointer faults appear as wrong read order or wrong full/empty flags when the receive queue is filled to capacity and drained.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  localparam int WORD_W   = 16;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int LEN_W    = IDX_W + 1;
  localparam int MIN_BITS = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Index of the first (most significant) bit of a frame after clamping.
  function automatic logic [IDX_W-1:0] top_index(input logic [LEN_W-1:0] len);
    if (int'(len) < MIN_BITS)
      return IDX_W'(MIN_BITS - 1);
    else if (int'(len) > WORD_W)
      return IDX_W'(WORD_W - 1);
    else
      return IDX_W'(len - LEN_W'(1));
  endfunction

endpackage

// File: rtl/pfs_fifo.sv
module pfs_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  logic do_wr, do_rd;
  assign do_wr = wr_i && !full_o;
  assign do_rd = rd_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata_o = mem[rptr];
  assign full_o  = (count == (AW+1)'(DEPTH));
  assign empty_o = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_i |-> !full_o); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_i |-> !empty_o); // R10

endmodule

// File: rtl/pfs_clkgen.sv
module pfs_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             edge_o
);
  logic [DIV_W-1:0] cnt;

  assign edge_o = run_i && (cnt == half_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!run_i || edge_o)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pfs_engine.sv
module pfs_engine
  import pfs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  frame_bits_i,
  input  logic [DIV_W-1:0]  half_cfg_i,
  input  logic              rxd_i,
  output logic [DIV_W-1:0]  half_o,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              fss_o,
  output logic              txd_o,
  output logic              txd_oe_o
);
  phase_t            ph;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  top_idx;
  logic [WORD_W-1:0] tx_word;
  logic [WORD_W-1:0] rx_sh;
  logic              lsb_done;

  logic rise_after_lsb;
  logic launch;

  assign busy_o         = (ph != PH_IDLE);
  assign rise_after_lsb = edge_i && (ph == PH_DATA) && !sclk_o && lsb_done;
  assign launch         = !tx_empty_i && ((ph == PH_IDLE) || rise_after_lsb);
  assign tx_pop_o       = launch;
  assign rx_push_o      = rise_after_lsb;
  assign rx_word_o      = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      bit_idx  <= '0;
      top_idx  <= '0;
      tx_word  <= '0;
      rx_sh    <= '0;
      lsb_done <= 1'b0;
      half_o   <= DIV_W'(1);
      sclk_o   <= 1'b0;
      fss_o    <= 1'b0;
      txd_o    <= 1'b0;
      txd_oe_o <= 1'b0;
    end else if (launch) begin
      ph       <= PH_SYNC;
      tx_word  <= tx_data_i;
      top_idx  <= top_index(frame_bits_i);
      half_o   <= half_cfg_i;
      rx_sh    <= '0;
      lsb_done <= 1'b0;
      sclk_o   <= 1'b1;
      fss_o    <= 1'b1;
      txd_o    <= 1'b0;
      txd_oe_o <= 1'b1;
    end else if (busy_o && edge_i) begin
      if (sclk_o) begin
        // falling boundary: sample the remote bit
        sclk_o <= 1'b0;
        if (ph == PH_DATA) begin
          rx_sh <= {rx_sh[WORD_W-2:0], rxd_i};
          if (bit_idx == '0) lsb_done <= 1'b1;
        end
      end else if (ph == PH_SYNC) begin
        ph      <= PH_DATA;
        fss_o   <= 1'b0;
        sclk_o  <= 1'b1;
        bit_idx <= top_idx;
        txd_o   <= tx_word[top_idx];
      end else if (lsb_done) begin
        // nothing queued: close the frame, clock stays low
        ph       <= PH_IDLE;
        lsb_done <= 1'b0;
        txd_o    <= 1'b0;
        txd_oe_o <= 1'b0;
      end else begin
        sclk_o  <= 1'b1;
        bit_idx <= bit_idx - 1'b1;
        txd_o   <= tx_word[bit_idx - 1'b1];
      end
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sclk_o && !fss_o && !txd_oe_o)); // R2
  AST_PULSE_STARTS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fss_o) |-> $rose(sclk_o)); // R3
  AST_PULSE_ENDS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(fss_o) |-> $rose(sclk_o)); // R4
  AST_PUSH_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    rx_push_o |=> ($rose(fss_o) || !txd_oe_o)); // R8
  AST_CLOCK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> (busy_o || $past(busy_o))); // R6

endmodule

// File: rtl/pfs_rxtimeout.sv
module pfs_rxtimeout #(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_i,
  input  logic             has_data_i,
  input  logic             rd_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             flag_o
);
  logic [DIV_W:0]   sub;
  logic [TMO_W-1:0] periods;
  logic             restart;
  logic             period_end;

  assign restart    = rd_i || start_i || !idle_i || !has_data_i;
  assign period_end = (sub == {half_i, 1'b0} - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub     <= '0;
      periods <= '0;
      flag_o  <= 1'b0;
    end else if (restart) begin
      sub     <= '0;
      periods <= '0;
      if (rd_i || start_i) flag_o <= 1'b0;
    end else begin
      if (periods >= limit_i) flag_o <= 1'b1;
      if (period_end) begin
        sub <= '0;
        if (periods != {TMO_W{1'b1}}) periods <= periods + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  AST_TIMEOUT_NEEDS_IDLE_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(idle_i && has_data_i)); // R7

endmodule

// File: rtl/pfs_master.sv
module pfs_master
  import pfs_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  parameter int TMO_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [LEN_W-1:0]  frame_bits,
  input  logic [TMO_W-1:0]  timeout_periods,
  input  logic              tx_wr_en,
  input  logic [WORD_W-1:0] tx_wr_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_rd_en,
  output logic [WORD_W-1:0] rx_rd_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_timeout,
  output logic              rx_overrun,
  output logic              sclk,
  output logic              fss,
  output logic              txd,
  output logic              txd_oe,
  input  logic              rxd
);
  logic [DIV_W-1:0]  cfg_half;
  logic [DIV_W-1:0]  run_half;
  logic              tick;
  logic              tx_pop;
  logic [WORD_W-1:0] tx_head;
  logic              eng_push;
  logic [WORD_W-1:0] eng_word;
  logic              busy;

  assign cfg_half = (clk_div < DIV_W'(2)) ? DIV_W'(1) : (clk_div >> 1);

  pfs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (tx_wr_en && !tx_full),
    .wdata_i (tx_wr_data),
    .rd_i    (tx_pop),
    .rdata_o (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  pfs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (eng_push && !rx_full),
    .wdata_i (eng_word),
    .rd_i    (rx_rd_en && !rx_empty),
    .rdata_o (rx_rd_data),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  pfs_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy),
    .half_i (run_half),
    .edge_o (tick)
  );

  pfs_engine #(.DIV_W(DIV_W)) u_eng (
    .clk          (clk),
    .rst          (rst),
    .edge_i       (tick),
    .tx_empty_i   (tx_empty),
    .tx_data_i    (tx_head),
    .frame_bits_i (frame_bits),
    .half_cfg_i   (cfg_half),
    .rxd_i        (rxd),
    .half_o       (run_half),
    .tx_pop_o     (tx_pop),
    .rx_push_o    (eng_push),
    .rx_word_o    (eng_word),
    .busy_o       (busy),
    .sclk_o       (sclk),
    .fss_o        (fss),
    .txd_o        (txd),
    .txd_oe_o     (txd_oe)
  );

  pfs_rxtimeout #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_tmo (
    .clk        (clk),
    .rst        (rst),
    .idle_i     (!busy),
    .has_data_i (!rx_empty),
    .rd_i       (rx_rd_en && !rx_empty),
    .start_i    (tx_pop),
    .half_i     (cfg_half),
    .limit_i    (timeout_periods),
    .flag_o     (rx_timeout)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rx_overrun <= 1'b0;
    else if (eng_push && rx_full)
      rx_overrun <= 1'b1;
  end

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun); // R9
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (eng_push && rx_full && !rx_rd_en) |=> rx_full); // R9

endmodule

// File: tb/sim_pfs_master.sv
module sim_pfs_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div = 8'd4;
  logic [4:0]  frame_bits = 5'd8;
  logic [15:0] timeout_periods = 16'd1000;
  logic        tx_wr_en = 1'b0;
  logic [15:0] tx_wr_data = '0;
  logic        tx_full, tx_empty;
  logic        rx_rd_en = 1'b0;
  logic [15:0] rx_rd_data;
  logic        rx_full, rx_empty, rx_timeout, rx_overrun;
  logic        sclk, fss, txd, txd_oe;
  logic        rxd = 1'b0;

  always #10 clk = ~clk;

  pfs_master u0 (
    .clk(clk), .rst(rst), .clk_div(clk_div), .frame_bits(frame_bits),
    .timeout_periods(timeout_periods), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_timeout(rx_timeout), .rx_overrun(rx_overrun),
    .sclk(sclk), .fss(fss), .txd(txd), .txd_oe(txd_oe), .rxd(rxd)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  int cur_bits = 8;
  int cur_div  = 4;

  logic [15:0] exp_tx[$];
  logic [15:0] slave_q[$];
  logic [15:0] exp_rx[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lowmask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'h1 << n) - 1);
  endfunction

  // ---------------- monitor / remote device model ----------------
  logic        prev_sclk = 1'b0, prev_fss = 1'b0;
  bit          have_prev = 1'b0, in_frame = 1'b0;
  int          since = 0, bitcnt = 0, hi_cnt = 0, fss_cnt = 0;
  logic [15:0] mosi = '0, slave_word = '0, want;

  always @(negedge clk) begin
    if (rst) begin
      prev_sclk = 1'b0; prev_fss = 1'b0; have_prev = 1'b0; in_frame = 1'b0;
      since = 0; hi_cnt = 0; fss_cnt = 0;
    end else begin
      if (!txd_oe && !fss) begin have_prev = 1'b0; in_frame = 1'b0; end
      if (sclk && !prev_sclk) begin
        if (fss) begin
          if (have_prev)
            check(since == (cur_bits + 1) * cur_div, "R8 pulse spacing", since, (cur_bits + 1) * cur_div);
          have_prev = 1'b1; since = 0; in_frame = 1'b1; bitcnt = 0; mosi = '0;
          slave_word = (slave_q.size() > 0) ? slave_q.pop_front() : 16'h0;
        end else if (in_frame && bitcnt < cur_bits) begin
          mosi = {mosi[14:0], txd};
          rxd = slave_word[cur_bits - 1 - bitcnt];
          bitcnt++;
          if (bitcnt == cur_bits) begin
            want = ((exp_tx.size() > 0) ? exp_tx.pop_front() : 16'h0) & lowmask(cur_bits);
            check(mosi == want, "R1 R4 serial word", mosi, want);
          end
        end
      end
      if (sclk) hi_cnt++;
      else if (prev_sclk) begin
        check(hi_cnt == cur_div / 2, "R6 sclk high phase", hi_cnt, cur_div / 2);
        hi_cnt = 0;
      end
      if (fss) fss_cnt++;
      else if (prev_fss) begin
        check(fss_cnt == cur_div, "R3 pulse width", fss_cnt, cur_div);
        fss_cnt = 0;
      end
      since++;
      prev_sclk = sclk;
      prev_fss  = fss;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [15:0] w, input logic [15:0] s);
    exp_tx.push_back(w);
    slave_q.push_back(s);
    exp_rx.push_back(s & lowmask(cur_bits));
    while (tx_full) @(negedge clk);
    tx_wr_en   = 1'b1;
    tx_wr_data = w;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20000 && !(tx_empty && !txd_oe); i++) @(negedge clk);
    check(!sclk && !fss && !txd_oe, "R2 idle lines", {sclk, fss, txd_oe}, 0);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      e = exp_rx.pop_front();
      check(!rx_empty, "R10 rx queue holds word", rx_empty, 0);
      check(rx_rd_data == e, "R5 received word", rx_rd_data, e);
      rx_rd_en = 1'b1;
      @(negedge clk);
      rx_rd_en = 1'b0;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!sclk && !fss && !txd_oe, "R2 reset lines", {sclk, fss, txd_oe}, 0);
    check(tx_empty && rx_empty && !tx_full && !rx_full, "R10 reset flags",
          {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    check(!rx_timeout && !rx_overrun, "R9 reset status", {rx_timeout, rx_overrun}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // 8-bit frames, divide by 4, burst of four
    send(16'hF0A5, 16'h005A); send(16'h003C, 16'h00C3);
    send(16'h00FF, 16'h0000); send(16'h0001, 16'h0080);
    wait_idle();
    read_n(4);

    // 4-bit frames, divide by 2
    clk_div = 8'd2; frame_bits = 5'd4; cur_div = 2; cur_bits = 4;
    send(16'h0009, 16'h000A); send(16'h0006, 16'h0005); send(16'hFFF3, 16'h000C);
    wait_idle();
    read_n(3);

    // 16-bit frames, divide by 6
    clk_div = 8'd6; frame_bits = 5'd16; cur_div = 6; cur_bits = 16;
    send(16'hBEEF, 16'hCAFE); send(16'h8001, 16'h7FFE); send(16'h1234, 16'h0F0F);
    wait_idle();
    read_n(3);

    // R1 short length clamps to 4, R6 odd/low divider clamps to 2
    clk_div = 8'd1; frame_bits = 5'd2; cur_div = 2; cur_bits = 4;
    send(16'h000B, 16'h0003);
    wait_idle();
    read_n(1);
    clk_div = 8'd5; frame_bits = 5'd31; cur_div = 4; cur_bits = 16;
    send(16'hA50F, 16'h3C96);
    wait_idle();
    read_n(1);

    // R7 receive timeout
    clk_div = 8'd4; frame_bits = 5'd8; cur_div = 4; cur_bits = 8;
    timeout_periods = 16'd5;
    send(16'h0066, 16'h0099);
    wait_idle();
    check(!rx_timeout, "R7 no early timeout", rx_timeout, 0);
    repeat (40) @(negedge clk);
    check(rx_timeout, "R7 timeout raised", rx_timeout, 1);
    read_n(1);
    check(!rx_timeout, "R7 read clears timeout", rx_timeout, 0);
    timeout_periods = 16'd1000;

    // R9 overrun and R10 queue depth
    check(!rx_overrun, "R9 no overrun yet", rx_overrun, 0);
    clk_div = 8'd2; cur_div = 2;
    for (int i = 0; i < 10; i++) send(16'(i * 17 + 3), 16'(i * 29 + 1));
    wait_idle();
    check(rx_full, "R10 rx full after 8", rx_full, 1);
    check(rx_overrun, "R9 overrun set", rx_overrun, 1);
    read_n(8);
    check(rx_empty, "R9 dropped words absent", rx_empty, 1);
    exp_rx.delete();
    repeat (4) @(negedge clk);
    check(rx_overrun, "R9 overrun sticky", rx_overrun, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule